// File: doc/BRIEF.md
# Memory Network Interface Packetizer

This block sits between a network and a memory that answers in split transactions. Writes and read requests arriving from the network are queued in a receive FIFO with a fixed byte budget. The memory drains that FIFO at its own pace. Read data that the memory returns later is held in a transmit buffer with its own byte budget. From there it leaves toward the network in packets that never exceed a set maximum size.

Every item carries a byte count. A write costs the number of data bytes it carries. A read request costs a fixed request size, whatever its byte field says. The network side sees ready drop as soon as the remaining receive budget cannot take the offered item. The memory side sees ready drop when the transmit budget cannot take the offered response beat.

On the way out, each beat is marked when it closes a packet. The beat that closes a whole read response carries a second flag as well, so the far end can put the response back together. The last packet of a response may be shorter than the maximum. All budgets and sizes are parameters, in bytes, and the data path is a fixed number of bytes wide.

Top module: `mem_net_packetizer`

## Requirements
- R1: After reset, the receive side is ready for any item up to the budget, the memory side is ready for a full beat, and neither memValid nor pktValid is asserted.
- R2: Items leave on the memory side in arrival order, with their data word, their byte count and their kind flag (rxIsRead=1 for a read request, 0 for a write) unchanged.
- R3: A read request consumes REQ_BYTES (default 8) of receive budget whatever its rxBytes field holds. A write consumes rxBytes (1 to 4) bytes.
- R4: rxReady is high exactly when the unused receive budget (RX_BYTES, default 512, minus the bytes of queued items) is at least the cost of the offered item.
- R5: An item offered while rxReady is low is not stored, so the memory side delivers no entry for it.
- R6: rspReady is high exactly when the unused transmit budget (TX_BYTES, default 64, minus the bytes held) is at least rspBytes.
- R7: Response beats leave on the network side in order, with their data and byte count unchanged.
- R8: Within one response, pktLast marks the beat at which the byte total since the packet began reaches PKT_BYTES (default 16). A packet never holds more than PKT_BYTES bytes.
- R9: The beat that ends a response (rspEnd=1 on entry) leaves with both pktEnd and pktLast set, even when its packet is short. Packet counting starts again at zero for the next response.
- R10: Bytes are returned to a budget when their entry leaves. Once everything has drained, the full receive and transmit budgets are available again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxValid | input | 1 | Network offers an item |
| rxReady | output | 1 | Item will be taken at this edge |
| rxIsRead | input | 1 | 1 = read request, 0 = write |
| rxBytes | input | 3 | Byte count of a write (1 to 4) |
| rxData | input | 32 | Write data or read address |
| memValid | output | 1 | Receive FIFO head is available |
| memReady | input | 1 | Memory takes the head |
| memIsRead | output | 1 | Head kind |
| memBytes | output | 3 | Head byte count field |
| memData | output | 32 | Head data word |
| rspValid | input | 1 | Memory offers a response beat |
| rspReady | output | 1 | Beat will be taken at this edge |
| rspData | input | 32 | Response data |
| rspBytes | input | 3 | Valid bytes in the beat (1 to 4) |
| rspEnd | input | 1 | Beat closes the read response |
| pktValid | output | 1 | Outgoing beat is available |
| pktReady | input | 1 | Network takes the beat |
| pktData | output | 32 | Outgoing data |
| pktBytes | output | 3 | Valid bytes in the outgoing beat |
| pktLast | output | 1 | Beat closes a packet |
| pktEnd | output | 1 | Beat closes the read response |

## Verification
The assertions assume that the memory sends every beat of a response full (four bytes) except the one flagged rspEnd. They also assume PKT_BYTES is a multiple of the beat width and every byte count lies between 1 and 4. Under those assumptions a packet boundary always falls on a beat boundary. The bench builds each response length from 1 to 64 bytes as full beats followed by one short final beat, so it stays within these assumptions. It never offers a zero byte count, and it drives memReady and pktReady only through handshakes that the design has granted.

// File: rtl/mnp_pkg.sv
package mnp_pkg;

  // Handshake strobes issued by the control to the storage datapath.
  typedef struct packed {
    logic rxPush;
    logic memPop;
    logic rspPush;
    logic pktPop;
  } strobe_t;

endpackage

// File: rtl/mnp_fifo.sv
module mnp_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] headData,
  output logic             notEmpty
);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) store[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= bump(wrPtr);
      if (pop)  rdPtr <= bump(rdPtr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign headData = store[rdPtr];
  assign notEmpty = (count != '0);

  // R5: the byte budget upstream must keep the entry storage from overrunning
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (push && !pop) |-> (count < CNT_W'(DEPTH)));

  // R2: nothing is taken from an empty queue
  a_r2_no_underflow: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> (count != '0));

endmodule

// File: rtl/mnp_datapath.sv
module mnp_datapath
  import mnp_pkg::*;
#(
  parameter int RX_DEPTH = 512,
  parameter int TX_DEPTH = 64,
  parameter int DATA_W   = 32,
  parameter int BCW      = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic              rxIsRead,
  input  logic [BCW-1:0]    rxBytes,
  input  logic [DATA_W-1:0] rxData,
  input  logic [DATA_W-1:0] rspData,
  input  logic [BCW-1:0]    rspBytes,
  input  logic              rspEnd,
  output logic              rxNotEmpty,
  output logic              rxHeadRead,
  output logic [BCW-1:0]    rxHeadBytes,
  output logic [DATA_W-1:0] rxHeadData,
  output logic              txNotEmpty,
  output logic              txHeadEnd,
  output logic [BCW-1:0]    txHeadBytes,
  output logic [DATA_W-1:0] txHeadData
);

  localparam int ENT_W = 1 + BCW + DATA_W;

  logic [ENT_W-1:0] rxIn, rxHead, txIn, txHead;

  assign rxIn = {rxIsRead, rxBytes, rxData};
  assign txIn = {rspEnd, rspBytes, rspData};

  mnp_fifo #(.WIDTH(ENT_W), .DEPTH(RX_DEPTH)) u_rxq (
    .clk      (clk),
    .rstN     (rstN),
    .push     (strobe.rxPush),
    .pushData (rxIn),
    .pop      (strobe.memPop),
    .headData (rxHead),
    .notEmpty (rxNotEmpty)
  );

  mnp_fifo #(.WIDTH(ENT_W), .DEPTH(TX_DEPTH)) u_txq (
    .clk      (clk),
    .rstN     (rstN),
    .push     (strobe.rspPush),
    .pushData (txIn),
    .pop      (strobe.pktPop),
    .headData (txHead),
    .notEmpty (txNotEmpty)
  );

  assign {rxHeadRead, rxHeadBytes, rxHeadData} = rxHead;
  assign {txHeadEnd, txHeadBytes, txHeadData}  = txHead;

  // R2: a head that is offered but not taken holds still
  a_r2_head_hold: assert property (@(posedge clk) disable iff (!rstN)
    (rxNotEmpty && !strobe.memPop) |=> (rxNotEmpty && $stable(rxHead)));

  // R7: an outgoing beat that is not taken holds still
  a_r7_beat_hold: assert property (@(posedge clk) disable iff (!rstN)
    (txNotEmpty && !strobe.pktPop) |=> (txNotEmpty && $stable(txHead)));

endmodule

// File: rtl/mnp_ctrl.sv
module mnp_ctrl
  import mnp_pkg::*;
#(
  parameter int RX_BYTES  = 512,
  parameter int TX_BYTES  = 64,
  parameter int PKT_BYTES = 16,
  parameter int REQ_BYTES = 8,
  parameter int BCW       = 3,
  localparam int RXB_W = $clog2(RX_BYTES + 1),
  localparam int TXB_W = $clog2(TX_BYTES + 1),
  localparam int PKB_W = $clog2(PKT_BYTES + 1) + 1
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           rxValid,
  input  logic           rxIsRead,
  input  logic [BCW-1:0] rxBytes,
  input  logic           memReady,
  input  logic           rxNotEmpty,
  input  logic           rxHeadRead,
  input  logic [BCW-1:0] rxHeadBytes,
  input  logic           rspValid,
  input  logic [BCW-1:0] rspBytes,
  input  logic           pktReady,
  input  logic           txNotEmpty,
  input  logic           txHeadEnd,
  input  logic [BCW-1:0] txHeadBytes,
  output logic           rxReady,
  output logic           memValid,
  output logic           rspReady,
  output logic           pktValid,
  output logic           pktLast,
  output strobe_t        strobe
);

  logic [RXB_W-1:0] rxUsed, rxFree, rxInCost, rxOutCost;
  logic [TXB_W-1:0] txUsed, txFree;
  logic [PKB_W-1:0] pktAcc, pktSum;

  // Receive budget
  assign rxInCost  = rxIsRead   ? RXB_W'(REQ_BYTES) : RXB_W'(rxBytes);
  assign rxOutCost = rxHeadRead ? RXB_W'(REQ_BYTES) : RXB_W'(rxHeadBytes);
  assign rxFree    = RXB_W'(RX_BYTES) - rxUsed;
  assign rxReady   = (rxFree >= rxInCost);
  assign memValid  = rxNotEmpty;

  // Transmit budget
  assign txFree   = TXB_W'(TX_BYTES) - txUsed;
  assign rspReady = (txFree >= TXB_W'(rspBytes));
  assign pktValid = txNotEmpty;

  // Packet boundary
  assign pktSum  = pktAcc + PKB_W'(txHeadBytes);
  assign pktLast = pktValid && (txHeadEnd || (pktSum >= PKB_W'(PKT_BYTES)));

  always_comb begin
    strobe.rxPush  = rxValid  && rxReady;
    strobe.memPop  = memValid && memReady;
    strobe.rspPush = rspValid && rspReady;
    strobe.pktPop  = pktValid && pktReady;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxUsed <= '0;
    end else begin
      rxUsed <= rxUsed
              + (strobe.rxPush ? rxInCost  : '0)
              - (strobe.memPop ? rxOutCost : '0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txUsed <= '0;
    end else begin
      txUsed <= txUsed
              + (strobe.rspPush ? TXB_W'(rspBytes)    : '0)
              - (strobe.pktPop  ? TXB_W'(txHeadBytes) : '0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pktAcc <= '0;
    end else if (strobe.pktPop) begin
      pktAcc <= pktLast ? '0 : pktSum;
    end
  end

  // R4: queued receive bytes never exceed the budget
  a_r4_rx_budget: assert property (@(posedge clk) disable iff (!rstN)
    rxUsed <= RXB_W'(RX_BYTES));

  // R6: held transmit bytes never exceed the budget
  a_r6_tx_budget: assert property (@(posedge clk) disable iff (!rstN)
    txUsed <= TXB_W'(TX_BYTES));

  // R8: no packet grows beyond the maximum size
  a_r8_pkt_bound: assert property (@(posedge clk) disable iff (!rstN)
    pktValid |-> (pktSum <= PKB_W'(PKT_BYTES)));

  // R10: an empty queue holds no budget
  a_r10_rx_empty_free: assert property (@(posedge clk) disable iff (!rstN)
    !rxNotEmpty |-> (rxUsed == '0));

  a_r10_tx_empty_free: assert property (@(posedge clk) disable iff (!rstN)
    !txNotEmpty |-> (txUsed == '0));

endmodule

// File: rtl/mem_net_packetizer.sv
module mem_net_packetizer
  import mnp_pkg::*;
#(
  parameter int RX_BYTES  = 512,
  parameter int TX_BYTES  = 64,
  parameter int PKT_BYTES = 16,
  parameter int REQ_BYTES = 8,
  parameter int DATA_W    = 32,
  localparam int BEAT_BYTES = DATA_W / 8,
  localparam int BCW        = $clog2(BEAT_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  output logic              rxReady,
  input  logic              rxIsRead,
  input  logic [BCW-1:0]    rxBytes,
  input  logic [DATA_W-1:0] rxData,
  output logic              memValid,
  input  logic              memReady,
  output logic              memIsRead,
  output logic [BCW-1:0]    memBytes,
  output logic [DATA_W-1:0] memData,
  input  logic              rspValid,
  output logic              rspReady,
  input  logic [DATA_W-1:0] rspData,
  input  logic [BCW-1:0]    rspBytes,
  input  logic              rspEnd,
  output logic              pktValid,
  input  logic              pktReady,
  output logic [DATA_W-1:0] pktData,
  output logic [BCW-1:0]    pktBytes,
  output logic              pktLast,
  output logic              pktEnd
);

  strobe_t strobe;
  logic    rxNotEmpty, txNotEmpty, txHeadEnd;

  mnp_ctrl #(
    .RX_BYTES  (RX_BYTES),
    .TX_BYTES  (TX_BYTES),
    .PKT_BYTES (PKT_BYTES),
    .REQ_BYTES (REQ_BYTES),
    .BCW       (BCW)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .rxValid     (rxValid),
    .rxIsRead    (rxIsRead),
    .rxBytes     (rxBytes),
    .memReady    (memReady),
    .rxNotEmpty  (rxNotEmpty),
    .rxHeadRead  (memIsRead),
    .rxHeadBytes (memBytes),
    .rspValid    (rspValid),
    .rspBytes    (rspBytes),
    .pktReady    (pktReady),
    .txNotEmpty  (txNotEmpty),
    .txHeadEnd   (txHeadEnd),
    .txHeadBytes (pktBytes),
    .rxReady     (rxReady),
    .memValid    (memValid),
    .rspReady    (rspReady),
    .pktValid    (pktValid),
    .pktLast     (pktLast),
    .strobe      (strobe)
  );

  mnp_datapath #(
    .RX_DEPTH (RX_BYTES),
    .TX_DEPTH (TX_BYTES),
    .DATA_W   (DATA_W),
    .BCW      (BCW)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .rxIsRead    (rxIsRead),
    .rxBytes     (rxBytes),
    .rxData      (rxData),
    .rspData     (rspData),
    .rspBytes    (rspBytes),
    .rspEnd      (rspEnd),
    .rxNotEmpty  (rxNotEmpty),
    .rxHeadRead  (memIsRead),
    .rxHeadBytes (memBytes),
    .rxHeadData  (memData),
    .txNotEmpty  (txNotEmpty),
    .txHeadEnd   (txHeadEnd),
    .txHeadBytes (pktBytes),
    .txHeadData  (pktData)
  );

  assign pktEnd = pktValid && txHeadEnd;

endmodule

// File: tb/mem_net_packetizer_tb.sv
module mem_net_packetizer_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rstN = 0;
  logic        rxValid = 0, rxIsRead = 0;
  logic [2:0]  rxBytes = 3'd1;
  logic [31:0] rxData = '0;
  logic        memReady = 0;
  logic        rxReady, memValid, memIsRead;
  logic [2:0]  memBytes;
  logic [31:0] memData;
  logic        rspValid = 0, rspEnd = 0;
  logic [31:0] rspData = '0;
  logic [2:0]  rspBytes = 3'd4;
  logic        rspReady;
  logic        pktValid, pktLast, pktEnd;
  logic        pktReady = 0;
  logic [31:0] pktData;
  logic [2:0]  pktBytes;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_net_packetizer u_dut (
    .clk(clk), .rstN(rstN),
    .rxValid(rxValid), .rxReady(rxReady), .rxIsRead(rxIsRead),
    .rxBytes(rxBytes), .rxData(rxData),
    .memValid(memValid), .memReady(memReady), .memIsRead(memIsRead),
    .memBytes(memBytes), .memData(memData),
    .rspValid(rspValid), .rspReady(rspReady), .rspData(rspData),
    .rspBytes(rspBytes), .rspEnd(rspEnd),
    .pktValid(pktValid), .pktReady(pktReady), .pktData(pktData),
    .pktBytes(pktBytes), .pktLast(pktLast), .pktEnd(pktEnd)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // Offer one item for one cycle; report whether it was taken.
  task automatic rxTry(input bit isRd, input int nb, input int data, output bit took);
    @(negedge clk);
    rxValid = 1; rxIsRead = isRd; rxBytes = 3'(nb); rxData = data;
    #1 took = rxReady;
    @(posedge clk);
    #1 rxValid = 0;
  endtask

  task automatic memTake(input bit isRd, input int nb, input int data, input string req);
    @(negedge clk);
    memReady = 1;
    #1;
    chk(memValid, req, memValid, 1);
    chk(memIsRead == isRd, req, memIsRead, isRd);
    chk(memBytes == 3'(nb), req, memBytes, nb);
    chk(memData == data, req, memData, data);
    @(posedge clk);
    #1 memReady = 0;
  endtask

  function automatic int beatBytes(input int len, input int k);
    int rem = len - 4 * k;
    return (rem > 4) ? 4 : rem;
  endfunction

  function automatic int beatWord(input int len, input int k);
    return {8'(len), 8'(k), 16'hA5C3};
  endfunction

  task automatic sendRsp(input int len);
    int n = (len + 3) / 4;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      rspValid = 1; rspData = beatWord(len, k);
      rspBytes = 3'(beatBytes(len, k)); rspEnd = (k == n - 1);
      #1;
      chk(rspReady, "R6 room for beat", rspReady, 1);
      @(posedge clk);
      #1 rspValid = 0; rspEnd = 0;
    end
  endtask

  task automatic drainRsp(input int len);
    int n = (len + 3) / 4;
    int pos = 0;
    for (int k = 0; k < n; k++) begin
      int nb = beatBytes(len, k);
      bit endB = (k == n - 1);
      bit lastB = endB || (((pos + nb) % 16) == 0);
      if (((len + k) % 3) == 0) begin
        @(negedge clk);
        pktReady = 0;
      end
      @(negedge clk);
      pktReady = 1;
      #1;
      chk(pktValid, "R7 beat present", pktValid, 1);
      chk(pktData == beatWord(len, k), "R7 data order", pktData, beatWord(len, k));
      chk(pktBytes == 3'(nb), "R7 byte count", pktBytes, nb);
      chk(pktLast == lastB, "R8 packet boundary", pktLast, lastB);
      chk(pktEnd == endB, "R9 response end", pktEnd, endB);
      @(posedge clk);
      #1 pktReady = 0;
      pos += nb;
    end
    @(negedge clk);
    #1 chk(!pktValid, "R7 no extra beat", pktValid, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        chk(0, "watchdog", cycles, 150000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    bit took;
    repeat (3) @(posedge clk);
    #1 rstN = 1;

    // R1: reset state
    @(negedge clk);
    rxIsRead = 1; rspBytes = 3'd4;
    #1;
    chk(rxReady, "R1 rx ready after reset", rxReady, 1);
    chk(rspReady, "R1 rsp ready after reset", rspReady, 1);
    chk(!memValid, "R1 memValid low", memValid, 0);
    chk(!pktValid, "R1 pktValid low", pktValid, 0);

    // R4: fill receive budget with 4-byte writes
    for (int i = 0; i < 127; i++) begin
      rxTry(0, 4, 32'h1000 + i, took);
      chk(took, "R4 write accepted below budget", took, 1);
    end
    rxTry(1, 4, 32'h5555, took);
    chk(!took, "R3 R4 read needs 8 with 4 free", took, 0);
    rxTry(0, 4, 32'h1000 + 127, took);
    chk(took, "R4 exact fit accepted", took, 1);
    rxTry(0, 1, 32'hDEAD, took);
    chk(!took, "R5 full rejects 1 byte", took, 0);
    for (int i = 0; i < 128; i++) memTake(0, 4, 32'h1000 + i, "R2 R5 write order");
    @(negedge clk);
    #1 chk(!memValid, "R5 rejected item not stored", memValid, 0);

    // R3: read requests cost REQ_BYTES regardless of rxBytes
    for (int i = 0; i < 64; i++) begin
      rxTry(1, 1, 32'h8000 + i, took);
      chk(took, "R10 R3 read accepted", took, 1);
    end
    rxTry(0, 1, 32'hBEEF, took);
    chk(!took, "R3 budget full after 64 reads", took, 0);
    for (int i = 0; i < 64; i++) memTake(1, 1, 32'h8000 + i, "R2 read order");

    // R2: mixed kinds and sizes
    for (int i = 0; i < 40; i++) begin
      rxTry((i % 3) == 0, 1 + (i % 4), 32'hC000 + i, took);
      chk(took, "R4 mixed accepted", took, 1);
    end
    for (int i = 0; i < 40; i++) memTake((i % 3) == 0, 1 + (i % 4), 32'hC000 + i, "R2 mixed order");

    // R6-R9: every response length the transmit budget can hold
    for (int len = 1; len <= 64; len++) begin
      sendRsp(len);
      @(negedge clk);
      rspBytes = 3'd4;
      #1 chk(rspReady == ((64 - len) >= 4), "R6 full-beat room", rspReady, (64 - len) >= 4);
      rspBytes = 3'd1;
      #1 chk(rspReady == (len < 64), "R6 one-byte room", rspReady, len < 64);
      drainRsp(len);
    end

    // R10: both budgets restored
    @(negedge clk);
    rxIsRead = 1; rspBytes = 3'd4;
    #1;
    chk(rxReady, "R10 rx budget restored", rxReady, 1);
    chk(rspReady, "R10 tx budget restored", rspReady, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule